// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is one 8-bit peripheral port that moves data in both directions over a single shared bus. The host writes a byte into an output holding register. The peripheral pulls acknowledge low to take that byte: while acknowledge is low the port drives the bus, and at all other times it releases the bus. In the other direction, the peripheral places a byte on the bus and pulses strobe low. The port captures the byte into a separate input holding register, which the host then reads.

Each direction has its own handshake flag. An active-high input-full flag is set by strobe and cleared when the host read ends. An active-low output-full flag is set when the host write ends and cleared by acknowledge. Both directions share one interrupt line, and each direction's contribution is gated by its own enable flop. The host sets or clears those enables with a single-bit command that names a bit number. A mode write clears the enables and all handshake state.

All inputs are sampled on `clk`, and edges of the host and peripheral pulses are detected against the previous sample. Address decode and the physical tristate pad are outside this block: the block presents a drive value and an output-enable.

Top module: `bsp_port`

## Requirements
- R1: After synchronous reset, `ibf` is 0, `obf_n` is 1, `intr` is 0, `pad_oe` follows `ack_n`, and both interrupt enables are cleared.
- R2: `pad_oe` is 1 exactly while `ack_n` is 0. `pad_out` always carries the output holding register.
- R3: A clock edge that samples `stb_n` low loads the bus value into the input holding register, shown on `host_rdata`, and sets `ibf` to 1.
- R4: A rising edge of `host_rd_n` (sampled 0, then 1) clears `ibf`, unless strobe is low in the same cycle.
- R5: While `host_wr_n` is sampled low, `host_wdata` is loaded into the output holding register. A rising edge of `host_wr_n` drives `obf_n` to 0.
- R6: A clock edge that samples `ack_n` low (with no write rising edge in that cycle) returns `obf_n` to 1.
- R7: A rising edge of `stb_n` arms the input interrupt. `intr` is 1 while that term is armed, `ibf` is 1, `stb_n` is 1 and the input enable is set. A falling edge of `host_rd_n` disarms the term.
- R8: A rising edge of `ack_n` arms the output interrupt. `intr` is 1 while that term is armed, `obf_n` is 1, `ack_n` is 1 and the output enable is set. A falling edge of `host_wr_n` disarms the term.
- R9: A bit command (`ctl_we`=1) with `ctl_bit`=6 loads `ctl_val` into the output enable. With `ctl_bit`=4 it loads the input enable. Any other bit number has no effect. Clearing an enable masks its term on `intr` immediately.
- R10: When strobe and acknowledge are both low, the input holding register captures the value the port itself is driving.
- R11: A `mode_wr` pulse clears both enables, both handshake flags and both armed interrupt terms. The holding registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd_n | input | 1 | Host read pulse, active low |
| host_wr_n | input | 1 | Host write pulse, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Input holding register |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| ibf | output | 1 | Input buffer full, active high |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Merged interrupt request |
| pad_in | input | 8 | Value seen on the bus pins |
| pad_out | output | 8 | Value to drive on the bus pins |
| pad_oe | output | 1 | Bus drive enable |
| ctl_we | input | 1 | Bit set/clear command strobe |
| ctl_bit | input | 3 | Bit number of the command |
| ctl_val | input | 1 | Value to load into the named enable |
| mode_wr | input | 1 | Mode write, clears enables and handshake state |

## Verification
A stuck or missed edge detector shows up one clock later as a flag that fails to move: `ibf` stays high after a read, or `obf_n` stays low after acknowledge. A wrongly held armed term or enable shows on `intr` on the next clock, either as a request that survives the host pulse meant to clear it or as a request that appears after its enable was cleared. A wrong capture source during a collision shows on `host_rdata` one clock after the strobe, as the external pin value in place of the port's own drive.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int unsigned BSP_DW     = 8;
    localparam int unsigned BSP_SEL_W  = $clog2(BSP_DW);
    localparam int unsigned OUT_EN_BIT = 6;
    localparam int unsigned IN_EN_BIT  = 4;

    typedef logic [BSP_DW-1:0] bsp_data_t;

    // sampled levels of the four active-low pulses
    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic stb_n;
        logic ack_n;
    } hs_lvl_t;

    // detected transitions of those pulses
    typedef struct packed {
        logic rd_rise;
        logic rd_fall;
        logic wr_rise;
        logic wr_fall;
        logic stb_rise;
        logic ack_rise;
    } hs_edge_t;

    // value seen by the input latch: own drive wins while enabled
    function automatic bsp_data_t bus_view(input logic oe,
                                           input bsp_data_t drv,
                                           input bsp_data_t pin);
        return oe ? drv : pin;
    endfunction

endpackage

// File: rtl/bsp_edge_det.sv
module bsp_edge_det
    import bsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hs_lvl_t  lvl,
    output hs_edge_t ev
);

    hs_lvl_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    always_comb begin
        ev.rd_rise  = ~prev.rd_n  &  lvl.rd_n;
        ev.rd_fall  =  prev.rd_n  & ~lvl.rd_n;
        ev.wr_rise  = ~prev.wr_n  &  lvl.wr_n;
        ev.wr_fall  =  prev.wr_n  & ~lvl.wr_n;
        ev.stb_rise = ~prev.stb_n &  lvl.stb_n;
        ev.ack_rise = ~prev.ack_n &  lvl.ack_n;
    end

endmodule

// File: rtl/bsp_in_path.sv
module bsp_in_path
    import bsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      stb_n,
    input  hs_edge_t  ev,
    input  bsp_data_t bus_val,
    output bsp_data_t in_latch,
    output logic      ibf,
    output logic      in_pend
);

    always_ff @(posedge clk) begin
        if (rst) in_latch <= '0;
        else if (!stb_n) in_latch <= bus_val;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ibf     <= 1'b0;
            in_pend <= 1'b0;
        end else begin
            if (!stb_n)          ibf <= 1'b1;
            else if (ev.rd_rise) ibf <= 1'b0;
            if (ev.rd_fall)       in_pend <= 1'b0;
            else if (ev.stb_rise) in_pend <= 1'b1;
        end
    end

    assert_ibf_set_R3: assert property (@(posedge clk) disable iff (rst)
        (!stb_n && !clr) |=> ibf);
    assert_ibf_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.rd_rise && stb_n) |=> !ibf);
    assert_in_disarm_R7: assert property (@(posedge clk) disable iff (rst)
        ev.rd_fall |=> !in_pend);

endmodule

// File: rtl/bsp_out_path.sv
module bsp_out_path
    import bsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      wr_n,
    input  logic      ack_n,
    input  hs_edge_t  ev,
    input  bsp_data_t wdata,
    output bsp_data_t out_latch,
    output logic      obf,
    output logic      out_pend
);

    always_ff @(posedge clk) begin
        if (rst) out_latch <= '0;
        else if (!wr_n) out_latch <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            obf      <= 1'b0;
            out_pend <= 1'b0;
        end else begin
            if (ev.wr_rise)  obf <= 1'b1;
            else if (!ack_n) obf <= 1'b0;
            if (ev.wr_fall)       out_pend <= 1'b0;
            else if (ev.ack_rise) out_pend <= 1'b1;
        end
    end

    assert_obf_set_R5: assert property (@(posedge clk) disable iff (rst)
        (ev.wr_rise && !clr) |=> obf);
    assert_obf_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !ev.wr_rise) |=> !obf);
    assert_out_disarm_R8: assert property (@(posedge clk) disable iff (rst)
        ev.wr_fall |=> !out_pend);

endmodule

// File: rtl/bsp_irq_ctl.sv
module bsp_irq_ctl
    import bsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_wr,
    input  logic                 ctl_we,
    input  logic [BSP_SEL_W-1:0] ctl_bit,
    input  logic                 ctl_val,
    input  logic                 in_pend,
    input  logic                 ibf,
    input  logic                 stb_n,
    input  logic                 out_pend,
    input  logic                 obf,
    input  logic                 ack_n,
    output logic                 intr
);

    logic inte_out;
    logic inte_in;
    logic in_term;
    logic out_term;

    always_ff @(posedge clk) begin
        if (rst || mode_wr) begin
            inte_out <= 1'b0;
            inte_in  <= 1'b0;
        end else if (ctl_we) begin
            if (ctl_bit == BSP_SEL_W'(OUT_EN_BIT)) inte_out <= ctl_val;
            if (ctl_bit == BSP_SEL_W'(IN_EN_BIT))  inte_in  <= ctl_val;
        end
    end

    always_comb begin
        in_term  = inte_in  & in_pend  & ibf  & stb_n;
        out_term = inte_out & out_pend & ~obf & ack_n;
        intr     = in_term | out_term;
    end

    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (!inte_out && !inte_in));
    assert_en_off_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !ctl_val && ctl_bit == BSP_SEL_W'(OUT_EN_BIT) && !mode_wr)
        |=> !inte_out);

endmodule

// File: rtl/bsp_port.sv
module bsp_port
    import bsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_rd_n,
    input  logic                 host_wr_n,
    input  logic [BSP_DW-1:0]    host_wdata,
    output logic [BSP_DW-1:0]    host_rdata,
    input  logic                 stb_n,
    input  logic                 ack_n,
    output logic                 ibf,
    output logic                 obf_n,
    output logic                 intr,
    input  logic [BSP_DW-1:0]    pad_in,
    output logic [BSP_DW-1:0]    pad_out,
    output logic                 pad_oe,
    input  logic                 ctl_we,
    input  logic [BSP_SEL_W-1:0] ctl_bit,
    input  logic                 ctl_val,
    input  logic                 mode_wr
);

    hs_lvl_t   lvl;
    hs_edge_t  ev;
    bsp_data_t in_latch;
    bsp_data_t out_latch;
    bsp_data_t bus_val;
    logic      ibf_q;
    logic      obf_q;
    logic      in_pend;
    logic      out_pend;

    always_comb begin
        lvl.rd_n  = host_rd_n;
        lvl.wr_n  = host_wr_n;
        lvl.stb_n = stb_n;
        lvl.ack_n = ack_n;
        pad_oe    = ~ack_n;
        bus_val   = bus_view(pad_oe, out_latch, pad_in);
    end

    bsp_edge_det u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .ev  (ev)
    );

    bsp_in_path u_in (
        .clk      (clk),
        .rst      (rst),
        .clr      (mode_wr),
        .stb_n    (stb_n),
        .ev       (ev),
        .bus_val  (bus_val),
        .in_latch (in_latch),
        .ibf      (ibf_q),
        .in_pend  (in_pend)
    );

    bsp_out_path u_out (
        .clk       (clk),
        .rst       (rst),
        .clr       (mode_wr),
        .wr_n      (host_wr_n),
        .ack_n     (ack_n),
        .ev        (ev),
        .wdata     (host_wdata),
        .out_latch (out_latch),
        .obf       (obf_q),
        .out_pend  (out_pend)
    );

    bsp_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .ctl_we   (ctl_we),
        .ctl_bit  (ctl_bit),
        .ctl_val  (ctl_val),
        .in_pend  (in_pend),
        .ibf      (ibf_q),
        .stb_n    (stb_n),
        .out_pend (out_pend),
        .obf      (obf_q),
        .ack_n    (ack_n),
        .intr     (intr)
    );

    assign host_rdata = in_latch;
    assign pad_out    = out_latch;
    assign ibf        = ibf_q;
    assign obf_n      = ~obf_q;

    assert_collide_R10: assert property (@(posedge clk) disable iff (rst)
        (!stb_n && !ack_n) |=> (host_rdata == $past(pad_out)));
    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!stb_n && !ack_n) |-> !intr);

endmodule

// File: tb/bsp_port_bench.sv
module bsp_port_bench;

    localparam int PER = 10;
    localparam int NV  = 26;

    typedef struct packed {
        logic [3:0] req;
        logic       rd, wr, stb, ack;
        logic [7:0] din, wd;
        logic       cw;
        logic [2:0] cb;
        logic       cv, md;
        logic       e_ibf, e_obfn, e_intr, e_oe;
        logic [7:0] e_dout, e_rdat;
    } vec_t;

    // req, rd wr stb ack, pad_in, wdata, cw cb cv md, ibf obf_n intr oe, pad_out, rdata
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 0,1,0,0, 8'h00,8'h00}, // R1 idle
        '{4'd9,  1,1,1,1, 8'h00,8'h00, 1,3'd4,1,0, 0,1,0,0, 8'h00,8'h00}, // R9 in enable on
        '{4'd9,  1,1,1,1, 8'h00,8'h00, 1,3'd6,1,0, 0,1,0,0, 8'h00,8'h00}, // R9 out enable on
        '{4'd3,  1,1,0,1, 8'hA5,8'h00, 0,3'd0,0,0, 1,1,0,0, 8'h00,8'hA5}, // R3 strobe capture
        '{4'd7,  1,1,1,1, 8'h3C,8'h00, 0,3'd0,0,0, 1,1,1,0, 8'h00,8'hA5}, // R7 input request
        '{4'd7,  0,1,1,1, 8'h3C,8'h00, 0,3'd0,0,0, 1,1,0,0, 8'h00,8'hA5}, // R7 read fall clears
        '{4'd4,  1,1,1,1, 8'h3C,8'h00, 0,3'd0,0,0, 0,1,0,0, 8'h00,8'hA5}, // R4 read rise
        '{4'd5,  1,0,1,1, 8'h00,8'h5A, 0,3'd0,0,0, 0,1,0,0, 8'h5A,8'hA5}, // R5 write low
        '{4'd5,  1,1,1,1, 8'h00,8'hFF, 0,3'd0,0,0, 0,0,0,0, 8'h5A,8'hA5}, // R5 write rise
        '{4'd2,  1,1,1,0, 8'h00,8'h00, 0,3'd0,0,0, 0,1,0,1, 8'h5A,8'hA5}, // R2 R6 ack drives
        '{4'd8,  1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 0,1,1,0, 8'h5A,8'hA5}, // R8 output request
        '{4'd8,  1,0,1,1, 8'h00,8'hC3, 0,3'd0,0,0, 0,1,0,0, 8'hC3,8'hA5}, // R8 write fall clears
        '{4'd5,  1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 0,0,0,0, 8'hC3,8'hA5}, // R5
        '{4'd9,  1,1,1,1, 8'h00,8'h00, 1,3'd6,0,0, 0,0,0,0, 8'hC3,8'hA5}, // R9 out enable off
        '{4'd6,  1,1,1,0, 8'h00,8'h00, 0,3'd0,0,0, 0,1,0,1, 8'hC3,8'hA5}, // R6 ack clears
        '{4'd9,  1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 0,1,0,0, 8'hC3,8'hA5}, // R9 masked
        '{4'd9,  1,1,1,1, 8'h00,8'h00, 1,3'd3,1,0, 0,1,0,0, 8'hC3,8'hA5}, // R9 other bit ignored
        '{4'd9,  1,1,1,1, 8'h00,8'h00, 1,3'd6,1,0, 0,1,1,0, 8'hC3,8'hA5}, // R9 unmask
        '{4'd11, 1,1,1,1, 8'h00,8'h00, 0,3'd0,0,1, 0,1,0,0, 8'hC3,8'hA5}, // R11 mode write
        '{4'd11, 1,1,1,1, 8'h00,8'h00, 1,3'd6,1,0, 0,1,0,0, 8'hC3,8'hA5}, // R11 pend gone
        '{4'd5,  1,0,1,1, 8'h00,8'h77, 0,3'd0,0,0, 0,1,0,0, 8'h77,8'hA5}, // R5
        '{4'd5,  1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 0,0,0,0, 8'h77,8'hA5}, // R5
        '{4'd10, 1,1,0,0, 8'h11,8'h00, 0,3'd0,0,0, 1,1,0,1, 8'h77,8'h77}, // R10 collision
        '{4'd10, 1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 1,1,1,0, 8'h77,8'h77}, // R10 R8
        '{4'd7,  0,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 1,1,1,0, 8'h77,8'h77}, // R7
        '{4'd4,  1,1,1,1, 8'h00,8'h00, 0,3'd0,0,0, 0,1,1,0, 8'h77,8'h77}  // R4
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       host_rd_n, host_wr_n, stb_n, ack_n;
    logic [7:0] host_wdata, host_rdata, pad_in, pad_out;
    logic       ibf, obf_n, intr, pad_oe;
    logic       ctl_we, ctl_val, mode_wr;
    logic [2:0] ctl_bit;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(PER/2) clk = ~clk;

    bsp_port u_bsp_port (
        .clk(clk), .rst(rst),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .stb_n(stb_n), .ack_n(ack_n),
        .ibf(ibf), .obf_n(obf_n), .intr(intr),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .ctl_we(ctl_we), .ctl_bit(ctl_bit), .ctl_val(ctl_val),
        .mode_wr(mode_wr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic compare(input string tag, input logic [19:0] act,
                           input logic [19:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act ibf=%b obf_n=%b intr=%b oe=%b out=%h rd=%h exp ibf=%b obf_n=%b intr=%b oe=%b out=%h rd=%h",
                     tag, act[19], act[18], act[17], act[16], act[15:8], act[7:0],
                     exp[19], exp[18], exp[17], exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    task automatic idle_inputs();
        host_rd_n = 1; host_wr_n = 1; stb_n = 1; ack_n = 1;
        host_wdata = 0; pad_in = 0; ctl_we = 0; ctl_bit = 0; ctl_val = 0; mode_wr = 0;
    endtask

    function automatic logic [19:0] outs();
        return {ibf, obf_n, intr, pad_oe, pad_out, host_rdata};
    endfunction

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        compare("R1 reset", outs(), {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00});

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_rd_n = VEC[i].rd; host_wr_n = VEC[i].wr;
            stb_n = VEC[i].stb; ack_n = VEC[i].ack;
            pad_in = VEC[i].din; host_wdata = VEC[i].wd;
            ctl_we = VEC[i].cw; ctl_bit = VEC[i].cb; ctl_val = VEC[i].cv;
            mode_wr = VEC[i].md;
            @(posedge clk);
            #(PER/4);
            compare($sformatf("R%0d vec%0d", VEC[i].req, i), outs(),
                    {VEC[i].e_ibf, VEC[i].e_obfn, VEC[i].e_intr, VEC[i].e_oe,
                     VEC[i].e_dout, VEC[i].e_rdat});
        end

        // R2: acknowledge low drives the bus combinationally
        @(negedge clk);
        idle_inputs();
        ack_n = 0;
        #1;
        compare("R2 oe on", {19'd0, pad_oe}, 20'd1);
        ack_n = 1;
        #1;
        compare("R2 oe off", {19'd0, pad_oe}, 20'd0);

        // R1: mid-run reset clears flags set by a strobe and a write
        @(negedge clk);
        stb_n = 0; pad_in = 8'h42; host_wr_n = 0; host_wdata = 8'h24;
        @(negedge clk);
        stb_n = 1; host_wr_n = 1;
        @(negedge clk);
        compare("R3 R5 pre-reset", {ibf, obf_n, 18'd0}, {1'b1, 1'b0, 18'd0});
        rst = 1;
        @(posedge clk);
        #(PER/4);
        rst = 0;
        compare("R1 mid reset", {ibf, obf_n, intr, pad_oe, pad_out, host_rdata},
                {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00});

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule